// File: doc/BRIEF.md
# Character RAM Access Controller

This block sits between a host bus and the two internal memories of a character display controller: a 128-entry display data memory and a 64-entry glyph pattern memory. The host runs bus cycles with an enable strobe, a register-select line and a read/write line. Every cycle is acted upon when the enable strobe falls. Four kinds of access exist. An instruction sets the address or sets the step direction. A status read returns the busy flag and the address counter. A data write stores into the selected memory. A data read returns the contents of a read-ahead data register.

One address counter serves both memories. The most recent set-address instruction chooses which memory the later data accesses reach. Reads never go straight to the memory. The bus is served from a data register, and that register is reloaded only by a set-address instruction or by a data read. After a data read, the reload from the stepped address happens once the strobe has fallen. The host must poll the busy flag before it starts an access other than a status read. While the flag is set, such accesses are dropped.

Top module: `char_ram_access`

## Requirements
- R1: An instruction (rs=0, rw=0) with db[7]=1 loads the address counter with db[6:0] and selects the display memory for later data accesses.
- R2: An instruction with db[7:6]=01 loads the counter with db[5:0] (bit 6 cleared) and selects the glyph memory.
- R3: A status read (rs=0, rw=1) drives {busy, counter[6:0]} on db_out while the strobe is high. Busy rises after each accepted access other than a status read and stays high for BUSY_CYCLES clocks.
- R4: While busy is 1, an instruction, data write or data read is ignored entirely: the counter, memory selection, memories and data register are unchanged.
- R5: A data write (rs=1, rw=0) stores db into the selected memory at the counter, then steps the counter by +1 or -1. The instruction db[7:2]=000001 sets the direction from db[1] (1 = up, 0 = down).
- R6: Glyph memory keeps only db[4:0] of a write. Its data returned on reads has bits 7..5 at zero.
- R7: A data read (rs=1, rw=1) drives the data register on db_out while the strobe is high. After the strobe falls, the counter steps and the register is reloaded from the new address.
- R8: After a set-address instruction, the data register holds the contents of the newly addressed location.
- R9: Data writes and all other instructions leave the data register unchanged.
- R10: The counter wraps modulo 128 in the display memory and modulo 64 in the glyph memory, in both directions.
- R11: After reset the counter is 0, the display memory is selected, the direction is up, busy is 0, and db_out is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| e | input | 1 | Bus enable strobe; the access takes effect when it falls |
| rs | input | 1 | Register select: 0 instruction/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| db_in | input | 8 | Bus data from the host |
| db_out | output | 8 | Bus data to the host, valid while the strobe is high on reads |

## Verification
On every cycle, the assertions check the following:
- busy rises after each accepted access;
- an access that arrives while busy leaves the counter and the memory selection untouched;
- the counter stays inside the glyph range whenever that memory is selected;
- a write leaves the data register unchanged;
- the glyph reload clears the upper bits;
- the bus output returns to zero when the strobe is low.

Only the bench scenarios can show that the data comes back right. These scenarios are:
- full write and read sweeps of both memories;
- wrap-around in both directions;
- the stale value that a read returns after a write to the same location;
- the loss of an access dropped during busy.

// File: rtl/crac_pkg.sv
package crac_pkg;

  typedef enum logic [2:0] {
    K_NONE,
    K_INSTR,
    K_STATUS,
    K_WRITE,
    K_READ
  } acc_kind_e;

  typedef enum logic {
    SEL_DD = 1'b0,
    SEL_CG = 1'b1
  } mem_sel_e;

  typedef enum logic [1:0] {
    OP_NOP,
    OP_SET_DD,
    OP_SET_CG,
    OP_DIR
  } instr_op_e;

  function automatic instr_op_e decode_instr(input logic [7:0] code);
    if (code[7])
      return OP_SET_DD;
    else if (code[6])
      return OP_SET_CG;
    else if (code[5:2] == 4'b0001)
      return OP_DIR;
    else
      return OP_NOP;
  endfunction

  function automatic acc_kind_e classify(input logic sel, input logic rd);
    case ({sel, rd})
      2'b00:   return K_INSTR;
      2'b01:   return K_STATUS;
      2'b10:   return K_WRITE;
      default: return K_READ;
    endcase
  endfunction

endpackage

// File: rtl/crac_host_sync.sv
module crac_host_sync
  import crac_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e,
  input  logic              rs,
  input  logic              rw,
  input  logic [DATA_W-1:0] db_in,
  output logic              e_high,
  output logic              go,
  output logic              cap_rs,
  output logic              cap_rw,
  output acc_kind_e         kind,
  output logic [DATA_W-1:0] cap_db
);

  logic e_s, e_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_s    <= 1'b0;
      e_s2   <= 1'b0;
      go     <= 1'b0;
      cap_rs <= 1'b0;
      cap_rw <= 1'b0;
      cap_db <= '0;
    end else begin
      e_s  <= e;
      e_s2 <= e_s;
      go   <= e_s2 & ~e_s;
      if (e_s) begin
        cap_rs <= rs;
        cap_rw <= rw;
        cap_db <= db_in;
      end
    end
  end

  assign e_high = e_s;

  always_comb begin
    kind = classify(cap_rs, cap_rw);
  end

  // R7: one action per strobe fall
  a_r7_single_go: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

endmodule

// File: rtl/crac_addr_ctrl.sv
module crac_addr_ctrl
  import crac_pkg::*;
#(
  parameter int AC_W        = 7,
  parameter int CG_DEPTH    = 64,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] cap_db,
  output logic [AC_W-1:0]   ac,
  output mem_sel_e          tgt,
  output logic              busy,
  output logic              mem_we,
  output logic              refill
);

  localparam int CG_AW = $clog2(CG_DEPTH);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);
  localparam logic [AC_W-1:0] CG_MASK = AC_W'(CG_DEPTH - 1);

  logic          up;
  logic [BW-1:0] bcnt;
  logic          accept;
  instr_op_e     op;

  function automatic logic [AC_W-1:0] step(input logic [AC_W-1:0] a,
                                           input logic dir_up,
                                           input mem_sel_e s);
    logic [AC_W-1:0] n;
    n = dir_up ? a + 1'b1 : a - 1'b1;
    if (s == SEL_CG) n = n & CG_MASK;
    return n;
  endfunction

  assign accept = go && (kind != K_STATUS) && (kind != K_NONE) && !busy;
  assign busy   = (bcnt != '0);
  assign mem_we = accept && (kind == K_WRITE);

  always_comb begin
    op = decode_instr(cap_db);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ac     <= '0;
      tgt    <= SEL_DD;
      up     <= 1'b1;
      bcnt   <= '0;
      refill <= 1'b0;
    end else begin
      refill <= 1'b0;
      if (accept) begin
        bcnt <= BW'(BUSY_CYCLES);
      end else if (busy) begin
        bcnt <= bcnt - 1'b1;
      end
      if (accept) begin
        unique case (kind)
          K_INSTR: begin
            unique case (op)
              OP_SET_DD: begin
                ac     <= cap_db[AC_W-1:0];
                tgt    <= SEL_DD;
                refill <= 1'b1;
              end
              OP_SET_CG: begin
                ac     <= AC_W'(cap_db[CG_AW-1:0]);
                tgt    <= SEL_CG;
                refill <= 1'b1;
              end
              OP_DIR:  up <= cap_db[1];
              default: ;
            endcase
          end
          K_WRITE: ac <= step(ac, up, tgt);
          K_READ: begin
            ac     <= step(ac, up, tgt);
            refill <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  initial begin
    a_r3_busy_long_enough: assert (BUSY_CYCLES >= 4);
    a_r10_cg_fits: assert (CG_AW < AC_W);
  end

  // R3: busy follows every accepted access
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);

  // R4: accesses arriving while busy change nothing
  a_r4_ignored_when_busy: assert property (@(posedge clk) disable iff (rst)
    (go && busy) |=> ($stable(ac) && $stable(tgt)));

  // R10: glyph selection keeps the counter in range
  a_r10_cg_range: assert property (@(posedge clk) disable iff (rst)
    (tgt == SEL_CG) |-> ((ac & ~CG_MASK) == '0));

  // R5: data accesses move the counter
  a_r5_counter_moves: assert property (@(posedge clk) disable iff (rst)
    (accept && (kind == K_WRITE || kind == K_READ)) |=> (ac != $past(ac)));

  // R1: display set-address loads the counter
  a_r1_set_dd: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == K_INSTR && cap_db[7]) |=>
      (ac == $past(cap_db[AC_W-1:0]) && tgt == SEL_DD));

endmodule

// File: rtl/crac_sdp_ram.sv
module crac_sdp_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/char_ram_access.sv
module char_ram_access
  import crac_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int AC_W        = 7,
  parameter int DD_DEPTH    = 128,
  parameter int CG_DEPTH    = 64,
  parameter int CG_W        = 5,
  parameter int BUSY_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e,
  input  logic              rs,
  input  logic              rw,
  input  logic [DATA_W-1:0] db_in,
  output logic [DATA_W-1:0] db_out
);

  localparam int DD_AW = $clog2(DD_DEPTH);
  localparam int CG_AW = $clog2(CG_DEPTH);

  logic              e_high, go, cap_rs, cap_rw;
  acc_kind_e         kind;
  logic [DATA_W-1:0] cap_db;
  logic [AC_W-1:0]   ac;
  mem_sel_e          tgt;
  logic              busy, mem_we, refill, refill_q;
  logic [DATA_W-1:0] dd_q;
  logic [CG_W-1:0]   cg_q;
  logic [DATA_W-1:0] dr;

  crac_host_sync #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst(rst), .e(e), .rs(rs), .rw(rw), .db_in(db_in),
    .e_high(e_high), .go(go), .cap_rs(cap_rs), .cap_rw(cap_rw),
    .kind(kind), .cap_db(cap_db)
  );

  crac_addr_ctrl #(
    .AC_W(AC_W), .CG_DEPTH(CG_DEPTH), .DATA_W(DATA_W),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .cap_db(cap_db),
    .ac(ac), .tgt(tgt), .busy(busy), .mem_we(mem_we), .refill(refill)
  );

  crac_sdp_ram #(.DEPTH(DD_DEPTH), .WIDTH(DATA_W)) u_dd (
    .clk(clk), .we(mem_we && tgt == SEL_DD),
    .waddr(ac[DD_AW-1:0]), .wdata(cap_db),
    .raddr(ac[DD_AW-1:0]), .rdata(dd_q)
  );

  crac_sdp_ram #(.DEPTH(CG_DEPTH), .WIDTH(CG_W)) u_cg (
    .clk(clk), .we(mem_we && tgt == SEL_CG),
    .waddr(ac[CG_AW-1:0]), .wdata(cap_db[CG_W-1:0]),
    .raddr(ac[CG_AW-1:0]), .rdata(cg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      refill_q <= 1'b0;
      dr       <= '0;
      db_out   <= '0;
    end else begin
      refill_q <= refill;
      if (refill_q)
        dr <= (tgt == SEL_CG) ? {{(DATA_W-CG_W){1'b0}}, cg_q} : dd_q;
      if (e_high && cap_rw)
        db_out <= cap_rs ? dr : {busy, ac};
      else
        db_out <= '0;
    end
  end

  initial begin
    a_r3_status_width: assert (DATA_W == AC_W + 1);
    a_r10_dd_fills_counter: assert (DD_AW == AC_W);
  end

  // R9: a write never disturbs the data register
  a_r9_dr_hold_on_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(dr));

  // R6: glyph reload clears the upper bits
  a_r6_cg_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (refill_q && tgt == SEL_CG) |=> (dr[DATA_W-1:CG_W] == '0));

  // R11: bus output idles at zero when the strobe is low
  a_r11_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !e_high |=> (db_out == '0));

endmodule

// File: tb/sim_char_ram_access.sv
module sim_char_ram_access;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       e = 1'b0, rs = 1'b0, rw = 1'b0;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out;

  always #5 clk = ~clk;

  char_ram_access u0 (
    .clk(clk), .rst(rst), .e(e), .rs(rs), .rw(rw),
    .db_in(db_in), .db_out(db_out)
  );

  int n_chk = 0, n_fail = 0;

  logic [7:0] dd_m [128];
  logic [7:0] cg_m [64];
  int         ac_m = 0;
  bit         cg_sel = 1'b0;
  bit         up_m = 1'b1;
  logic [7:0] dr_m = 8'h00;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit r_s, input bit r_w, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    rs = r_s; rw = r_w; db_in = d; e = 1'b1;
    repeat (4) @(negedge clk);
    q = db_out;
    e = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_idle(output logic [7:0] q);
    int guard = 0;
    do begin
      bus(1'b0, 1'b1, 8'h00, q);
      guard++;
    end while (q[7] && guard < 100);
  endtask

  function automatic logic [7:0] mem_at(input int a);
    return cg_sel ? cg_m[a & 63] : dd_m[a & 127];
  endfunction

  function automatic int stepped(input int a);
    int n = up_m ? a + 1 : a - 1;
    return cg_sel ? (n & 63) : (n & 127);
  endfunction

  task automatic check_ac(input string tag);
    logic [7:0] q;
    wait_idle(q);
    chk(tag, q, {1'b0, 7'(ac_m)});
  endtask

  task automatic do_instr(input logic [7:0] d);
    logic [7:0] q;
    wait_idle(q);
    bus(1'b0, 1'b0, d, q);
    if (d[7]) begin
      ac_m = d[6:0]; cg_sel = 1'b0; dr_m = mem_at(ac_m);
    end else if (d[6]) begin
      ac_m = d[5:0]; cg_sel = 1'b1; dr_m = mem_at(ac_m);
    end else if (d[5:2] == 4'b0001) begin
      up_m = d[1];
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    logic [7:0] q;
    wait_idle(q);
    bus(1'b1, 1'b0, d, q);
    if (cg_sel) cg_m[ac_m] = d & 8'h1F;
    else        dd_m[ac_m] = d;
    ac_m = stepped(ac_m);
  endtask

  task automatic do_read(input string tag);
    logic [7:0] q;
    wait_idle(q);
    bus(1'b1, 1'b1, 8'h00, q);
    chk(tag, q, dr_m);
    ac_m = stepped(ac_m);
    dr_m = mem_at(ac_m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %h expected %h", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R11: idle output and reset state
    chk("R11 idle bus", db_out, 8'h00);
    bus(1'b0, 1'b1, 8'h00, q);
    chk("R11 reset status", q, 8'h00);

    // R1, R5, R10: fill display memory upward, wrap back to 0
    do_instr(8'h80);
    check_ac("R1 set dd 0");
    for (int i = 0; i < 128; i++) do_write(8'((i * 37 + 11) & 255));
    check_ac("R10 dd wrap up");

    // R7, R8: read display memory back
    do_instr(8'h80);
    for (int i = 0; i < 128; i++) do_read("R7 dd read sweep");

    // R2, R6, R10: glyph memory sweep
    do_instr(8'h40);
    check_ac("R2 set cg 0");
    for (int i = 0; i < 64; i++) do_write(8'(i) ^ 8'hA5);
    check_ac("R10 cg wrap up");
    do_instr(8'h40 | 8'd5);
    for (int i = 0; i < 64; i++) do_read("R6 cg read sweep");

    // R5, R10: down direction, wraps in both memories
    do_instr(8'h04);
    do_instr(8'h80 | 8'd5);
    do_write(8'h3C); do_write(8'h4D); do_write(8'h5E);
    check_ac("R5 dd down step");
    do_instr(8'h80 | 8'd3);
    do_read("R5 dd down read 3");
    do_read("R5 dd down read 2");
    do_instr(8'h80);
    do_read("R10 dd read at 0");
    check_ac("R10 dd wrap down");
    do_instr(8'h40);
    do_write(8'hFF);
    check_ac("R10 cg wrap down");
    do_instr(8'h06);

    // R9: write leaves stale data register
    do_instr(8'h80 | 8'd10);
    do_write(8'h77);
    do_read("R9 stale after write");
    do_read("R9 next after stale");
    do_instr(8'h80 | 8'd10);
    do_read("R8 refreshed after set");
    do_instr(8'h80 | 8'd20);
    do_instr(8'h01);
    do_instr(8'h10);
    do_read("R9 other instr keep dr");

    // R3: busy visible right after an accepted access
    do_instr(8'h80 | 8'd7);
    bus(1'b0, 1'b1, 8'h00, q);
    chk("R3 busy set", q, 8'h87);
    check_ac("R3 busy clears");

    // R4: accesses during busy are dropped
    do_instr(8'h80 | 8'd60);
    bus(1'b1, 1'b0, 8'h5A, q);
    bus(1'b0, 1'b0, 8'h80 | 8'd33, q);
    check_ac("R4 counter kept");
    do_read("R4 memory kept");
    do_instr(8'h80 | 8'd60);
    do_read("R4 memory kept again");
    do_read("R4 read after drop");
    bus(1'b1, 1'b1, 8'h00, q);
    check_ac("R4 read during busy dropped");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule